// File: doc/BRIEF.md
# Windowed Register File

This block is the register file of a RISC core. Software always sees 32 logical registers. Eight of them are globals, shared by every procedure. The other 24 come from a sliding window over a circular stack of physical registers, and a current-window pointer selects that window. A window has three groups: eight outgoing registers (logical 8..15), eight private locals (logical 16..23) and eight incoming registers (logical 24..31).

A call moves the pointer down by one window, which is 16 physical registers. The caller's outgoing registers then appear to the callee as its incoming registers. A return moves the pointer back up. Either move completes in one cycle while it stays inside the live part of the stack. A window-invalid mask marks the windows that cannot be entered. A move that would enter such a window raises an overflow or underflow flag, so that external trap logic can spill or fill. That logic reloads the mask through a load input after it has done so.

The block has two combinational read ports and one write port. A write is forwarded to a read of the same physical register in the same cycle.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 1..7 are globals: each maps to the same storage whatever the window pointer is.
- R2: At window w, logical register k (8..31) maps to stack slot (16*w + k - 8) modulo 16*NWIN. After a call, the callee's registers 24..31 therefore hold the caller's registers 8..15.
- R3: The locals (16..23) of one window are private: a write to them in one window does not appear in the locals of any other window.
- R4: A call alone, with a valid target window (cwp-1 modulo NWIN), sets cwp to that target at the next edge. A return alone, with a valid target (cwp+1 modulo NWIN), sets cwp to that target.
- R5: A call alone whose target window has its mask bit set drives ovf_o high in the same cycle and leaves cwp unchanged.
- R6: A return alone whose target window has its mask bit set drives unf_o high in the same cycle and leaves cwp unchanged.
- R7: Logical register 0 always reads zero, and writes to it are discarded, including the same-cycle bypass.
- R8: A write whose physical target equals a read port's physical target shows its data on that read port in the same cycle.
- R9: Synchronous reset sets cwp to 0 and sets the mask to only bit 1 (the window a return from window 0 would enter). Every register reads zero after reset.
- R10: When call_i and ret_i are high together, the window does not move and neither flag rises.
- R11: When wim_ld is high, wim_in (bit n is window n) replaces the mask at the next edge. A move in that same cycle is judged against the old mask.
- R12: The window pointer wraps modulo NWIN. The incoming registers of window NWIN-1 are the outgoing registers of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Request a call (window down by one) |
| ret_i | input | 1 | Request a return (window up by one) |
| wim_ld | input | 1 | Load the window-invalid mask |
| wim_in | input | NWIN | New mask value, bit n for window n |
| cwp_o | output | clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Call refused: target window is invalid |
| unf_o | output | 1 | Return refused: target window is invalid |
| ra_a | input | 5 | Read port A logical address |
| rd_a | output | DW | Read port A data |
| ra_b | input | 5 | Read port B logical address |
| rd_b | output | DW | Read port B data |
| we | input | 1 | Write enable |
| wa | input | 5 | Write logical address |
| wd | input | DW | Write data |

## Verification
The bench builds the block with NWIN=4 and DW=16, which gives 72 physical registers. With only four windows, a few calls are enough to go all the way round the stack. The pointer wraps from 0 to 3, and the incoming registers of window 3 alias the outgoing registers of window 0. The reset mask causes an overflow after two calls and an underflow on the very first return, so both refusals are reached in a handful of cycles. Reloading the mask then shows the refusal boundary moving.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int NGLOB = 8;     // global registers
    localparam int WSTEP = 16;    // physical registers per window step
    localparam int LAW   = 5;     // logical address width

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_CALL = 2'd1,
        MV_RET  = 2'd2
    } move_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } wflag_t;

    // window below w (target of a call)
    function automatic int win_down(int w, int nwin);
        return (w == 0) ? nwin - 1 : w - 1;
    endfunction

    // window above w (target of a return)
    function automatic int win_up(int w, int nwin);
        return (w == nwin - 1) ? 0 : w + 1;
    endfunction

    // logical register at window w to physical index
    function automatic int phys_of(int w, int lreg, int nwin);
        int off;
        if (lreg < NGLOB) begin
            return lreg;
        end
        off = WSTEP * w + (lreg - NGLOB);
        if (off >= WSTEP * nwin) begin
            off = off - WSTEP * nwin;
        end
        return NGLOB + off;
    endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = 3,
    parameter int PHW  = 8
) (
    input  logic [PW-1:0]  cwp,
    input  logic [LAW-1:0] lreg,
    output logic [PHW-1:0] preg
);

    always_comb begin
        preg = PHW'(phys_of(int'(cwp), int'(lreg), NWIN));
    end

endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            wim_ld,
    input  logic [NWIN-1:0] wim_in,
    output logic [PW-1:0]   cwp,
    output wflag_t          flags
);

    // only the window above window 0 starts invalid
    localparam logic [NWIN-1:0] WIM_RST = NWIN'(2);

    logic [NWIN-1:0] wim_q;
    logic [PW-1:0]   cwp_q;
    logic [PW-1:0]   cwp_d;
    logic [PW-1:0]   tgt_dn;
    logic [PW-1:0]   tgt_up;
    move_e           mv;

    always_comb begin
        if (call_i && !ret_i) begin
            mv = MV_CALL;
        end else if (ret_i && !call_i) begin
            mv = MV_RET;
        end else begin
            mv = MV_NONE;
        end
        tgt_dn    = PW'(win_down(int'(cwp_q), NWIN));
        tgt_up    = PW'(win_up(int'(cwp_q), NWIN));
        flags.ovf = (mv == MV_CALL) && wim_q[tgt_dn];
        flags.unf = (mv == MV_RET) && wim_q[tgt_up];
        cwp_d     = cwp_q;
        case (mv)
            MV_CALL: if (!flags.ovf) cwp_d = tgt_dn;
            MV_RET:  if (!flags.unf) cwp_d = tgt_up;
            default: cwp_d = cwp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            wim_q <= WIM_RST;
        end else begin
            cwp_q <= cwp_d;
            if (wim_ld) begin
                wim_q <= wim_in;
            end
        end
    end

    assign cwp = cwp_q;

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int NPHYS = 136,
    parameter int PHW   = 8,
    parameter int DW    = 32,
    parameter int NRD   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [PHW-1:0] wp,
    input  logic [DW-1:0]  wd,
    input  logic [PHW-1:0] rp [NRD],
    output logic [DW-1:0]  rd [NRD]
);

    logic [DW-1:0] mem [NPHYS];
    logic          wr_ok;

    // physical 0 is the hardwired zero register
    assign wr_ok = we && (wp != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ok) begin
            mem[wp] <= wd;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (rp[g] == '0) begin
                rd[g] = '0;
            end else if (wr_ok && (wp == rp[g])) begin
                rd[g] = wd;
            end else begin
                rd[g] = mem[rp[g]];
            end
        end
    end

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     call_i,
    input  logic                     ret_i,
    input  logic                     wim_ld,
    input  logic [NWIN-1:0]          wim_in,
    output logic [$clog2(NWIN)-1:0]  cwp_o,
    output logic                     ovf_o,
    output logic                     unf_o,
    input  logic [4:0]               ra_a,
    output logic [DW-1:0]            rd_a,
    input  logic [4:0]               ra_b,
    output logic [DW-1:0]            rd_b,
    input  logic                     we,
    input  logic [4:0]               wa,
    input  logic [DW-1:0]            wd
);

    localparam int PW    = $clog2(NWIN);
    localparam int NPHYS = NGLOB + WSTEP * NWIN;
    localparam int PHW   = $clog2(NPHYS);
    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 1;

    logic [PW-1:0]  cwp;
    wflag_t         flags;
    logic [LAW-1:0] lad [NMAP];
    logic [PHW-1:0] pad [NMAP];
    logic [PHW-1:0] rp  [NRD];
    logic [DW-1:0]  rdv [NRD];

    regwin_ptr #(
        .NWIN (NWIN),
        .PW   (PW)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .call_i (call_i),
        .ret_i  (ret_i),
        .wim_ld (wim_ld),
        .wim_in (wim_in),
        .cwp    (cwp),
        .flags  (flags)
    );

    assign lad[0] = ra_a;
    assign lad[1] = ra_b;
    assign lad[2] = wa;

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        regwin_map #(
            .NWIN (NWIN),
            .PW   (PW),
            .PHW  (PHW)
        ) u_map (
            .cwp  (cwp),
            .lreg (lad[g]),
            .preg (pad[g])
        );
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rp
        assign rp[g] = pad[g];
    end

    regwin_store #(
        .NPHYS (NPHYS),
        .PHW   (PHW),
        .DW    (DW),
        .NRD   (NRD)
    ) u_store (
        .clk (clk),
        .rst (rst),
        .we  (we),
        .wp  (pad[NRD]),
        .wd  (wd),
        .rp  (rp),
        .rd  (rdv)
    );

    assign cwp_o = cwp;
    assign ovf_o = flags.ovf;
    assign unf_o = flags.unf;
    assign rd_a  = rdv[0];
    assign rd_b  = rdv[1];

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    call_i,
    input logic                    ret_i,
    input logic                    ovf_o,
    input logic                    unf_o,
    input logic [$clog2(NWIN)-1:0] cwp_o,
    input logic [4:0]              ra_a,
    input logic [DW-1:0]           rd_a
);

    localparam int PW = $clog2(NWIN);
    localparam logic [PW-1:0] TOPW = PW'(NWIN - 1);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> (cwp_o == $past(cwp_o)));

    // R6
    unf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> (cwp_o == $past(cwp_o)));

    // R4
    call_step_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && !ovf_o) |=>
        (cwp_o == (($past(cwp_o) == PW'(0)) ? TOPW : $past(cwp_o) - 1'b1)));

    // R4
    ret_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !unf_o) |=>
        (cwp_o == (($past(cwp_o) == TOPW) ? PW'(0) : $past(cwp_o) + 1'b1)));

    // R10
    both_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |-> (!ovf_o && !unf_o));

    // R10
    both_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |=> (cwp_o == $past(cwp_o)));

    // R7
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_a == 5'd0) |-> (rd_a == '0));

    // R9
    reset_cwp_chk: assert property (@(posedge clk)
        rst |=> (cwp_o == PW'(0)));

endmodule

bind regwin_file regwin_file_chk #(
    .NWIN (NWIN),
    .DW   (DW)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .call_i (call_i),
    .ret_i  (ret_i),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o),
    .cwp_o  (cwp_o),
    .ra_a   (ra_a),
    .rd_a   (rd_a)
);

// File: tb/regwin_file_test.sv
module regwin_file_test;

    localparam int NWIN = 4;
    localparam int DW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          call_i = 1'b0;
    logic          ret_i = 1'b0;
    logic          wim_ld = 1'b0;
    logic [3:0]    wim_in = '0;
    logic [1:0]    cwp_o;
    logic          ovf_o;
    logic          unf_o;
    logic [4:0]    ra_a = '0;
    logic [DW-1:0] rd_a;
    logic [4:0]    ra_b = '0;
    logic [DW-1:0] rd_b;
    logic          we = 1'b0;
    logic [4:0]    wa = '0;
    logic [DW-1:0] wd = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    regwin_file #(.NWIN(NWIN), .DW(DW)) uut (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .wim_ld(wim_ld), .wim_in(wim_in), .cwp_o(cwp_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .ra_a(ra_a), .rd_a(rd_a),
        .ra_b(ra_b), .rd_b(rd_b), .we(we), .wa(wa), .wd(wd)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        we = 1'b1; wa = a; wd = d;
        step();
        we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [DW-1:0] exp);
        ra_a = a; ra_b = a;
        #1;
        chk({tag, " portA"}, 32'(rd_a), 32'(exp));
        chk({tag, " portB"}, 32'(rd_b), 32'(exp));
    endtask

    task automatic mv(input string tag, input bit c, input bit r,
                      input bit e_ovf, input bit e_unf, input int e_cwp);
        call_i = c; ret_i = r;
        #1;
        chk({tag, " ovf"}, 32'(ovf_o), 32'(e_ovf));
        chk({tag, " unf"}, 32'(unf_o), 32'(e_unf));
        step();
        call_i = 1'b0; ret_i = 1'b0;
        chk({tag, " cwp"}, 32'(cwp_o), 32'(e_cwp));
    endtask

    task automatic t_reset();
        chk("R9 cwp after reset", 32'(cwp_o), 32'd0);
        rd_chk("R9 global 1 zero", 5'd1, '0);
        rd_chk("R9 out 8 zero", 5'd8, '0);
        rd_chk("R9 local 20 zero", 5'd20, '0);
        rd_chk("R9 in 31 zero", 5'd31, '0);
    endtask

    task automatic t_zero();
        wr(5'd0, 16'hABCD);
        rd_chk("R7 r0 after write", 5'd0, '0);
        we = 1'b1; wa = 5'd0; wd = 16'h1234; ra_a = 5'd0;
        #1;
        chk("R7 r0 no bypass", 32'(rd_a), 32'd0);
        step();
        we = 1'b0;
    endtask

    task automatic t_fwd();
        we = 1'b1; wa = 5'd5; wd = 16'h5A5A; ra_b = 5'd5; ra_a = 5'd6;
        #1;
        chk("R8 bypass port B", 32'(rd_b), 32'h5A5A);
        chk("R8 other port untouched", 32'(rd_a), 32'h0);
        step();
        we = 1'b0;
        rd_chk("R8 stored value", 5'd5, 16'h5A5A);
    endtask

    task automatic t_windows();
        wr(5'd3, 16'h1111);
        wr(5'd8, 16'hA008);
        wr(5'd16, 16'hA016);
        wr(5'd24, 16'hA024);
        mv("R4 R12 call wraps 0 to 3", 1'b1, 1'b0, 1'b0, 1'b0, 3);
        rd_chk("R2 R12 callee in = caller out", 5'd24, 16'hA008);
        rd_chk("R3 callee local empty", 5'd16, '0);
        rd_chk("R2 callee out empty", 5'd8, '0);
        rd_chk("R1 global seen in window 3", 5'd3, 16'h1111);
        wr(5'd16, 16'hB016);
        wr(5'd3, 16'h2222);
        mv("R4 R12 return wraps 3 to 0", 1'b0, 1'b1, 1'b0, 1'b0, 0);
        rd_chk("R3 caller local intact", 5'd16, 16'hA016);
        rd_chk("R2 caller out intact", 5'd8, 16'hA008);
        rd_chk("R2 caller in intact", 5'd24, 16'hA024);
        rd_chk("R1 global written in window 3", 5'd3, 16'h2222);
    endtask

    task automatic t_limits();
        mv("R4 call 0 to 3", 1'b1, 1'b0, 1'b0, 1'b0, 3);
        mv("R4 call 3 to 2", 1'b1, 1'b0, 1'b0, 1'b0, 2);
        mv("R5 call into invalid 1", 1'b1, 1'b0, 1'b1, 1'b0, 2);
        mv("R4 return 2 to 3", 1'b0, 1'b1, 1'b0, 1'b0, 3);
        mv("R4 return 3 to 0", 1'b0, 1'b1, 1'b0, 1'b0, 0);
        mv("R6 R9 return into invalid 1", 1'b0, 1'b1, 1'b0, 1'b1, 0);
    endtask

    task automatic t_both();
        mv("R10 call and return together", 1'b1, 1'b1, 1'b0, 1'b0, 0);
    endtask

    task automatic t_mask();
        wim_ld = 1'b1; wim_in = 4'b0100; ret_i = 1'b1;
        #1;
        chk("R11 old mask still rules", 32'(unf_o), 32'd1);
        step();
        wim_ld = 1'b0; ret_i = 1'b0;
        chk("R11 refused under old mask", 32'(cwp_o), 32'd0);
        mv("R11 return now allowed 0 to 1", 1'b0, 1'b1, 1'b0, 1'b0, 1);
        mv("R6 R11 return into new invalid 2", 1'b0, 1'b1, 1'b0, 1'b1, 1);
        mv("R4 R11 call 1 to 0", 1'b1, 1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero();
        t_fwd();
        t_windows();
        t_limits();
        t_both();
        t_mask();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R-all actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule